// File: doc/BRIEF.md
# Polled Edge Timestamp Capture Unit

This block watches one asynchronous input pin and, while it is both enabled and set to input direction, treats chosen transitions of that pin as events. Each qualifying transition stores the value of a free-running system time bus (`time_in`) and advances an event counter. There is no interrupt: software learns about events only by polling the register interface.

The last-event timestamp and the counter are each wider than a 32-bit bus word. A read of the timestamp low word also copies the current timestamp and the current count into a snapshot. Later reads of the timestamp high word and of both snapshot count words return that copy, so a multiword readout cannot tear even while new edges keep arriving. The running count also stays readable on its own pair of words.

Top module: `tsc_edge_capture`

## Requirements
- R1: After synchronous reset every readable word (control, captured time, snapshot count, live count) reads as zero.
- R2: The control word at offset 0x00 holds enable in bit 0, input direction in bit 1 and edge select in bits 3:2. It reads back those four bits, and bits 31:4 read as zero.
- R3: Pin transitions change neither the live count nor the captured time unless enable and input direction are both 1.
- R4: Edge select 0 counts rising transitions only, 1 counts falling only, 2 counts both, and 3 counts none.
- R5: The live count at 0x30 (low) and 0x34 (high), zero-extended from CNT_W bits, grows by one for each qualifying transition and wraps to zero after 2^CNT_W - 1.
- R6: When enable changes from 0 to 1 the live count is cleared to zero; a transition in that same cycle is not counted.
- R7: The pin passes through a two-flop synchronizer. For a transition first sampled at clock edge n, the captured time is the `time_in` value present at clock edge n+2.
- R8: A read of 0x20 returns the low word of the last captured time and copies the captured time and the live count into a snapshot. Reads of 0x24, 0x28 and 0x2C return the snapshot time high word and the snapshot count low and high words, unchanged by later transitions.
- R9: If a transition is captured in the same cycle as a read of 0x20, the read data and the snapshot hold the values from before that transition, and the live count and captured time include it.
- R10: Read data appears on `rdata` one clock after `rd_en`. Unmapped offsets read as zero, and writes to any offset other than 0x00 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous monitored pin |
| time_in | input | TS_W | Free-running system time value |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after `rd_en` |

## Verification
The bench builds the block with TS_W = 64 and CNT_W = 8. The narrow counter lets a sweep of a few hundred transitions reach the wraparound of R5. The time bus starts just below a 32-bit boundary, so captured times cross from one high word to the next during the run. Every edge-select code is swept against each combination of enable and direction, and the count expected for each pattern is worked out from the sequence of pin levels. A transition is placed in the exact cycle of a low-word read to exercise the collision ordering of R9.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int ADDR_W = 6;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SEL_RISE = 2'd0,
        SEL_FALL = 2'd1,
        SEL_BOTH = 2'd2,
        SEL_NONE = 2'd3
    } edge_sel_e;

    // Packed so that en lands in bit 0, dir_in in bit 1, sel in bits 3:2
    typedef struct packed {
        edge_sel_e sel;
        logic      dir_in;
        logic      en;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_TS_LO = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_TS_HI = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_SC_LO = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_SC_HI = 6'h2C;
    localparam logic [ADDR_W-1:0] OFS_LC_LO = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_LC_HI = 6'h34;

    function automatic logic edge_qualifies(edge_sel_e s, logic rise, logic fall);
        logic q;
        unique case (s)
            SEL_RISE: q = rise;
            SEL_FALL: q = fall;
            SEL_BOTH: q = rise | fall;
            default:  q = 1'b0;
        endcase
        return q;
    endfunction

    function automatic logic addr_mapped(logic [ADDR_W-1:0] a);
        return (a == OFS_CTRL)  || (a == OFS_TS_LO) || (a == OFS_TS_HI) ||
               (a == OFS_SC_LO) || (a == OFS_SC_HI) || (a == OFS_LC_LO) ||
               (a == OFS_LC_HI);
    endfunction

endpackage

// File: rtl/tsc_sync_edge.sv
module tsc_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-2:0], pin_in};
    end

    logic cur_lvl, prev_lvl;
    assign cur_lvl  = chain[SYNC_STAGES-1];
    assign prev_lvl = chain[SYNC_STAGES];

    always_comb begin
        rise = cur_lvl & ~prev_lvl;
        fall = ~cur_lvl & prev_lvl;
    end
endmodule

// File: rtl/tsc_event_core.sv
module tsc_event_core #(
    parameter int TS_W  = 64,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             hit,
    input  logic [TS_W-1:0]  time_in,
    output logic [CNT_W-1:0] live_cnt,
    output logic [TS_W-1:0]  last_ts
);
    logic en_q;
    logic clr;

    assign clr = en & ~en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            live_cnt <= '0;
            last_ts  <= '0;
        end else begin
            en_q <= en;
            if (clr)      live_cnt <= '0;
            else if (hit) live_cnt <= live_cnt + CNT_W'(1);
            if (hit)      last_ts  <= time_in;
        end
    end
endmodule

// File: rtl/tsc_regfile.sv
module tsc_regfile
    import tsc_pkg::*;
#(
    parameter int TS_W  = 64,
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic [TS_W-1:0]   last_ts,
    output ctrl_t             ctrl,
    output logic [TS_W-1:0]   snap_ts,
    output logic [CNT_W-1:0]  snap_cnt,
    output logic [WORD_W-1:0] rdata
);
    localparam int EXT_W  = 2 * WORD_W;
    localparam int CTRL_W = $bits(ctrl_t);

    logic [EXT_W-1:0] ts_ext, cnt_ext, sts_ext, scnt_ext;

    always_comb begin
        ts_ext   = '0;
        cnt_ext  = '0;
        sts_ext  = '0;
        scnt_ext = '0;
        ts_ext[TS_W-1:0]    = last_ts;
        cnt_ext[CNT_W-1:0]  = live_cnt;
        sts_ext[TS_W-1:0]   = snap_ts;
        scnt_ext[CNT_W-1:0] = snap_cnt;
    end

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^wdata[WORD_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            snap_ts  <= '0;
            snap_cnt <= '0;
            rdata    <= '0;
        end else begin
            if (wr_en && addr == OFS_CTRL)
                ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (rd_en) begin
                unique case (addr)
                    OFS_CTRL:  rdata <= {{(WORD_W-CTRL_W){1'b0}}, ctrl};
                    OFS_TS_LO: begin
                        rdata    <= ts_ext[WORD_W-1:0];
                        snap_ts  <= last_ts;
                        snap_cnt <= live_cnt;
                    end
                    OFS_TS_HI: rdata <= sts_ext[EXT_W-1:WORD_W];
                    OFS_SC_LO: rdata <= scnt_ext[WORD_W-1:0];
                    OFS_SC_HI: rdata <= scnt_ext[EXT_W-1:WORD_W];
                    OFS_LC_LO: rdata <= cnt_ext[WORD_W-1:0];
                    OFS_LC_HI: rdata <= cnt_ext[EXT_W-1:WORD_W];
                    default:   rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tsc_edge_capture.sv
module tsc_edge_capture
    import tsc_pkg::*;
#(
    parameter int TS_W        = 64,
    parameter int CNT_W       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic [TS_W-1:0]   time_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    ctrl_t            ctrl_q;
    logic             rise, fall, hit, in_mode;
    logic [CNT_W-1:0] live_cnt, snap_cnt;
    logic [TS_W-1:0]  last_ts, snap_ts;

    tsc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .rise   (rise),
        .fall   (fall)
    );

    assign in_mode = ctrl_q.en & ctrl_q.dir_in;
    assign hit     = in_mode & edge_qualifies(ctrl_q.sel, rise, fall);

    tsc_event_core #(.TS_W(TS_W), .CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl_q.en),
        .hit      (hit),
        .time_in  (time_in),
        .live_cnt (live_cnt),
        .last_ts  (last_ts)
    );

    tsc_regfile #(.TS_W(TS_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .live_cnt (live_cnt),
        .last_ts  (last_ts),
        .ctrl     (ctrl_q),
        .snap_ts  (snap_ts),
        .snap_cnt (snap_cnt),
        .rdata    (rdata)
    );
endmodule

// File: rtl/tsc_edge_capture_chk.sv
module tsc_edge_capture_chk
    import tsc_pkg::*;
#(
    parameter int TS_W  = 64,
    parameter int CNT_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              ctrl_en,
    input logic              hit,
    input logic [TS_W-1:0]   time_in,
    input logic [TS_W-1:0]   last_ts,
    input logic [CNT_W-1:0]  live_cnt,
    input logic [TS_W-1:0]   snap_ts,
    input logic [CNT_W-1:0]  snap_cnt,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] rdata
);
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> $stable(live_cnt));

    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && $past(ctrl_en)) |=> (live_cnt == $past(live_cnt) + CNT_W'(1)));

    p_clear_on_enable_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_en) |-> ##2 (live_cnt == CNT_W'($past(hit))));

    p_stamp_on_hit_r7: assert property (@(posedge clk) disable iff (rst)
        hit |=> (last_ts == $past(time_in)));

    p_snap_on_read_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFS_TS_LO) |=>
            (snap_cnt == $past(live_cnt) && snap_ts == $past(last_ts)));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !addr_mapped(addr)) |=> (rdata == '0));
endmodule

bind tsc_edge_capture tsc_edge_capture_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl_en  (ctrl_q.en),
    .hit      (hit),
    .time_in  (time_in),
    .last_ts  (last_ts),
    .live_cnt (live_cnt),
    .snap_ts  (snap_ts),
    .snap_cnt (snap_cnt),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata)
);

// File: tb/sim_tsc_edge_capture.sv
module sim_tsc_edge_capture;
    localparam int TS_W  = 64;
    localparam int CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_in = 1'b0;
    logic [63:0] time_q = 64'h0000_0001_FFFF_FFF0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    logic [63:0] m_cnt;
    logic [63:0] m_ts;

    always #10 clk = ~clk;
    always @(posedge clk) time_q <= time_q + 64'd1;

    tsc_edge_capture #(.TS_W(TS_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .time_in(time_q),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    // Toggle the pin and update the model for the given control settings
    task automatic toggle(input logic en, input logic dir, input logic [1:0] sel);
        logic q;
        @(negedge clk);
        pin_in = ~pin_in;
        case (sel)
            2'd0: q = pin_in;
            2'd1: q = ~pin_in;
            2'd2: q = 1'b1;
            default: q = 1'b0;
        endcase
        if (en && dir && q) begin
            m_cnt = (m_cnt + 64'd1) % 64'd256;
            m_ts  = time_q + 64'd2;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic set_mode(input logic en, input logic dir, input logic [1:0] sel);
        wr(6'h00, 32'h0);
        wr(6'h00, {28'h0, sel, dir, en});
        if (en) m_cnt = 64'd0;
    endtask

    initial begin
        logic [31:0] d, d2;
        logic [63:0] old_ts, old_cnt;
        m_cnt = 0; m_ts = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(6'h00, d); check("R1 ctrl", {32'h0, d}, 64'h0);
        rd(6'h20, d); check("R1 ts lo", {32'h0, d}, 64'h0);
        rd(6'h24, d); check("R1 ts hi", {32'h0, d}, 64'h0);
        rd(6'h28, d); check("R1 snap lo", {32'h0, d}, 64'h0);
        rd(6'h34, d); check("R1 live hi", {32'h0, d}, 64'h0);

        // R2: control readback
        wr(6'h00, 32'hFFFF_FFF9);
        rd(6'h00, d); check("R2 ctrl bits", {32'h0, d}, 64'h9);
        wr(6'h00, 32'h0);

        // R3: not in input mode, transitions ignored
        for (int m = 0; m < 3; m++) begin
            logic e, r;
            e = (m == 1); r = (m == 2);
            set_mode(e, r, 2'd2);
            for (int k = 0; k < 3; k++) toggle(e, r, 2'd2);
            rd(6'h30, d); check("R3 live count idle", {32'h0, d}, m_cnt);
            rd(6'h20, d); check("R3 ts untouched", {32'h0, d}, 64'h0);
        end

        // R4 and R7: sweep edge selects
        for (int s = 0; s < 4; s++) begin
            set_mode(1'b1, 1'b1, 2'(s));
            for (int k = 0; k < 5; k++) toggle(1'b1, 1'b1, 2'(s));
            rd(6'h30, d); check("R4 live count per select", {32'h0, d}, m_cnt);
            rd(6'h20, d); check("R7 ts lo", {32'h0, d}, {32'h0, m_ts[31:0]});
            rd(6'h24, d); check("R7 ts hi", {32'h0, d}, {32'h0, m_ts[63:32]});
            rd(6'h28, d); check("R8 snap count lo", {32'h0, d}, m_cnt);
            rd(6'h2C, d); check("R8 snap count hi", {32'h0, d}, 64'h0);
        end

        // R5: wraparound with both-edges mode
        set_mode(1'b1, 1'b1, 2'd2);
        for (int k = 0; k < 260; k++) toggle(1'b1, 1'b1, 2'd2);
        rd(6'h30, d); check("R5 wrap lo", {32'h0, d}, m_cnt);
        rd(6'h34, d); check("R5 wrap hi", {32'h0, d}, 64'h0);
        rd(6'h20, d); check("R7 ts lo after wrap", {32'h0, d}, {32'h0, m_ts[31:0]});
        rd(6'h24, d); check("R7 ts hi after wrap", {32'h0, d}, {32'h0, m_ts[63:32]});

        // R6: disable holds count, re-enable clears
        wr(6'h00, 32'h0000_000A);
        for (int k = 0; k < 3; k++) toggle(1'b0, 1'b1, 2'd2);
        rd(6'h30, d); check("R3 disabled hold", {32'h0, d}, m_cnt);
        set_mode(1'b1, 1'b1, 2'd2);
        rd(6'h30, d); check("R6 cleared on enable", {32'h0, d}, 64'h0);

        // R8: snapshot stays while edges continue
        toggle(1'b1, 1'b1, 2'd2);
        rd(6'h20, d);
        old_ts = m_ts; old_cnt = m_cnt;
        toggle(1'b1, 1'b1, 2'd2);
        toggle(1'b1, 1'b1, 2'd2);
        rd(6'h24, d); check("R8 snap ts hi", {32'h0, d}, {32'h0, old_ts[63:32]});
        rd(6'h28, d); check("R8 snap count frozen", {32'h0, d}, old_cnt);
        rd(6'h30, d); check("R8 live count moves", {32'h0, d}, m_cnt);

        // R9: edge captured in the same cycle as a low-word read
        old_ts = m_ts; old_cnt = m_cnt;
        @(negedge clk);
        pin_in = ~pin_in;
        m_ts = time_q + 64'd2;
        m_cnt = (m_cnt + 64'd1) % 64'd256;
        @(negedge clk);
        @(negedge clk); rd_en = 1'b1; addr = 6'h20;
        @(negedge clk); rd_en = 1'b0; d = rdata;
        check("R9 read sees pre-edge ts", {32'h0, d}, {32'h0, old_ts[31:0]});
        repeat (2) @(negedge clk);
        rd(6'h28, d); check("R9 snapshot pre-edge count", {32'h0, d}, old_cnt);
        rd(6'h30, d); check("R9 live includes edge", {32'h0, d}, m_cnt);
        rd(6'h20, d); check("R9 new ts lo", {32'h0, d}, {32'h0, m_ts[31:0]});
        rd(6'h24, d); check("R9 new ts hi", {32'h0, d}, {32'h0, m_ts[63:32]});

        // R10: unmapped reads and ignored writes
        rd(6'h04, d); check("R10 unmapped 04", {32'h0, d}, 64'h0);
        rd(6'h3C, d); check("R10 unmapped 3C", {32'h0, d}, 64'h0);
        wr(6'h30, 32'h55);
        wr(6'h20, 32'hAA);
        rd(6'h30, d); check("R10 write to live ignored", {32'h0, d}, m_cnt);
        rd(6'h20, d2); check("R10 write to ts ignored", {32'h0, d2}, {32'h0, m_ts[31:0]});
        rd(6'h00, d); check("R10 ctrl unchanged", {32'h0, d}, 64'hB);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule